// File: doc/BRIEF.md
# Trace Unit Power-Down Lock Controller

This block guards the register file of a processor trace unit across a power-down save and restore sequence. It decodes an APB-style register port and classifies each access. A sideband flag on the port marks whether the access comes from an external debugger or from software running on the processor. The block holds a software lock, a lock status view and a power-down status view. While the lock is set, it refuses debugger accesses to trace-class registers with an error response. All other accesses are passed through: they are forwarded to the trace register file or answered locally.

Setting the lock raises a stop request towards the trace pipeline. Once the pipeline reports that it has drained, a status bit tells software that the trace registers may be saved or restored. A build parameter selects one of two variants. The full power-down variant comes out of reset locked. The single-power variant has no lock, and its lock and power-down status registers read back fixed constants.

Top module: `tpd_ctrl`

## Requirements
- R1: Lock status register (offset 0x304): bit 3 reads 1 in the full build and 0 in the single-power build, and bit 0 always reads 0.
- R2: In the single-power build, writes to the lock access register (0x300) are ignored, the lock status register reads 0x00000000, the power-down status register (0x314) reads 0x00000001, `trc_stop` stays 0, and no access ever gets an error.
- R3: In the full build, the lock is set by reset. Bit 1 of the lock status register and bit 5 of the power-down status register both show the lock state, and `trc_stop` is high while the lock is set.
- R4: A write to 0x300 from either requester sets the lock when the data equals 0x5EC010CC and clears it for any other data, taking effect from the next cycle.
- R5: While locked, an access with `pdbg`=1 to a trace-class register completes with `pslverr`=1, `trc_acc`=0 and read data 0. Every other access gets `pslverr`=0. A trace-class access that is not refused pulses `trc_acc` and returns `trc_rdata`. `pready` is always 1.
- R6: Trace-class registers are all offsets below 0x300 except the main status register at 0x010, plus the claim-set (0xFA0) and claim-clear (0xFA4) registers.
- R7: Bit 1 of the main status register (0x010) is set one cycle after `trc_idle` is seen high while the lock is set. It clears at the same edge at which the lock clears. A drain acknowledge that arrives in the same cycle as a clearing write does not set it.
- R8: Clearing the lock before the idle bit is set drops `trc_stop` in the next cycle, and the clearing write completes without error.
- R9: In the full build, bit 1 of the power-down status register is set by reset and cleared by any read of that register. Its value has no effect on whether an access is refused.
- R10: The save/restore offset 0x308 and all other offsets outside the decoded set read 0, never give an error, never pulse `trc_acc`, and ignore writes. The lock access register also reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the trace unit |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of the register port |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address of the register |
| pwdata | input | 32 | Write data |
| pdbg | input | 1 | 1 = access from external debugger, 0 = from processor software |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1; no wait states |
| pslverr | output | 1 | Error response for a refused access |
| trc_acc | output | 1 | Forward strobe to the trace register file for a permitted trace-class access |
| trc_rdata | input | 32 | Read data returned by the trace register file |
| trc_stop | output | 1 | Stop-tracing request to the trace pipeline |
| trc_idle | input | 1 | Drained indication from the trace pipeline |

## Verification
Two events can land in the same cycle: the drain acknowledge from the pipeline, and a register write that clears the lock. The bench raises `trc_idle` exactly at the access phase of the clearing write. It then reads the main status register and checks that the idle bit stays 0 and that `trc_stop` has fallen. A second overlap is also checked. A debugger access with the sticky bit still set from reset is judged only against the lock state, before and after the sticky bit is consumed by a read.

// File: rtl/tpd_pkg.sv
// Shared constants and types for the trace power-down lock controller.
// Offsets are byte addresses; the lock key and offsets are fixed by the
// register map that software and debuggers decode.
package tpd_pkg;

    localparam int unsigned OFF_STATUS    = 32'h010;
    localparam int unsigned OFF_LOCK_ACC  = 32'h300;
    localparam int unsigned OFF_LOCK_STAT = 32'h304;
    localparam int unsigned OFF_PD_STAT   = 32'h314;
    localparam int unsigned OFF_CLAIM_SET = 32'hFA0;
    localparam int unsigned OFF_CLAIM_CLR = 32'hFA4;
    localparam int unsigned TRACE_LIMIT   = 32'h300;

    localparam logic [31:0] LOCK_KEY = 32'h5EC0_10CC;

    typedef enum logic [2:0] {
        CLS_TRACE,
        CLS_STATUS,
        CLS_LOCK_ACC,
        CLS_LOCK_STAT,
        CLS_PD_STAT,
        CLS_OTHER
    } reg_cls_e;

endpackage

// File: rtl/tpd_decode.sv
// Address classifier.
// Maps a register address onto the register class that decides gating and
// read data. Assumes byte addressing; a partial-word address matches nothing
// special and so falls into its range class.
module tpd_decode
    import tpd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_cls_e          cls
);

    // Classify the address: local registers first, then trace-class ranges.
    always_comb begin
        if (addr == ADDR_W'(OFF_STATUS))
            cls = CLS_STATUS;
        else if (addr == ADDR_W'(OFF_LOCK_ACC))
            cls = CLS_LOCK_ACC;
        else if (addr == ADDR_W'(OFF_LOCK_STAT))
            cls = CLS_LOCK_STAT;
        else if (addr == ADDR_W'(OFF_PD_STAT))
            cls = CLS_PD_STAT;
        else if (addr < ADDR_W'(TRACE_LIMIT) ||
                 addr == ADDR_W'(OFF_CLAIM_SET) ||
                 addr == ADDR_W'(OFF_CLAIM_CLR))
            cls = CLS_TRACE;
        else
            cls = CLS_OTHER;
    end

endmodule

// File: rtl/tpd_lock.sv
// Lock state, drain handshake and sticky power-down flag.
// Full build: the lock is set by reset, the stop request follows the lock,
// and the idle bit is set one cycle after a drain acknowledge seen under the
// lock. Single-power build: no state, all outputs tied low.
// Assumes lock_wr and pd_rd are single-cycle access-phase strobes.
module tpd_lock #(
    parameter bit          FULL_PD = 1'b1,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] KEY     = 32'h5EC0_10CC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] lock_wdata,
    input  logic              pd_rd,
    input  logic              trc_idle,
    output logic              locked,
    output logic              idle_ok,
    output logic              sticky
);

    generate
        if (FULL_PD) begin : g_full
            logic locked_q;
            logic idle_q;
            logic sticky_q;
            logic locked_d;
            logic key_hit;

            assign key_hit = (lock_wdata == DATA_W'(KEY));

            // Next lock state from a key write; the lock holds otherwise.
            always_comb begin
                if (lock_wr)
                    locked_d = key_hit;
                else
                    locked_d = locked_q;
            end

            // Lock, idle and sticky registers; the lock and sticky bit come up set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    locked_q <= 1'b1;
                    idle_q   <= 1'b0;
                    sticky_q <= 1'b1;
                end else begin
                    locked_q <= locked_d;
                    idle_q   <= locked_d & (idle_q | (locked_q & trc_idle));
                    if (pd_rd)
                        sticky_q <= 1'b0;
                end
            end

            assign locked  = locked_q;
            assign idle_ok = idle_q;
            assign sticky  = sticky_q;

            assert_key_sets_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (lock_wr && key_hit) |=> locked);

            assert_clear_drops_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (lock_wr && !key_hit) |=> (!locked && !idle_ok));

            assert_idle_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(idle_ok) |-> ($past(trc_idle) && $past(locked)));

            assert_sticky_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
                pd_rd |=> !sticky);
        end else begin : g_single
            assign locked  = 1'b0;
            assign idle_ok = 1'b0;
            assign sticky  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/tpd_resp.sv
// Access gating and response generation.
// Decides for each access phase whether it is refused, forwarded to the
// trace register file or answered locally, and builds the read data.
// Assumes a zero-wait register port: the response is combinational.
module tpd_resp
    import tpd_pkg::*;
#(
    parameter bit FULL_PD = 1'b1,
    parameter int DATA_W  = 32
) (
    input  logic              access,
    input  logic              pwrite,
    input  logic              pdbg,
    input  reg_cls_e          cls,
    input  logic              locked,
    input  logic              idle_ok,
    input  logic              sticky,
    input  logic [DATA_W-1:0] trc_rdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr,
    output logic              trc_acc,
    output logic              lock_wr,
    output logic              pd_rd
);

    localparam logic [DATA_W-1:0] SP_PD_STAT = DATA_W'(1);

    logic is_trace;
    logic blocked;

    // Refusal applies only to debugger accesses of trace-class registers under lock.
    always_comb begin
        is_trace = (cls == CLS_TRACE);
        blocked  = access & is_trace & pdbg & locked;
        pslverr  = blocked;
        trc_acc  = access & is_trace & ~blocked;
        lock_wr  = access & pwrite & (cls == CLS_LOCK_ACC);
        pd_rd    = access & ~pwrite & (cls == CLS_PD_STAT);
    end

    // Read data mux; writes and idle cycles return zero.
    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            case (cls)
                CLS_TRACE:     prdata = blocked ? '0 : trc_rdata;
                CLS_STATUS:    prdata = DATA_W'({idle_ok, 1'b0});
                CLS_LOCK_STAT: prdata = FULL_PD ? DATA_W'({1'b1, 1'b0, locked, 1'b0}) : '0;
                CLS_PD_STAT:   prdata = FULL_PD ? DATA_W'({locked, 3'b000, sticky, 1'b1})
                                                : SP_PD_STAT;
                default:       prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tpd_ctrl.sv
// Trace unit power-down lock controller, top level.
// Joins the address classifier, lock/handshake state and response logic
// behind an APB-style port with a debugger/processor requester flag.
// Assumes psel/penable follow the two-phase port protocol with no waits.
module tpd_ctrl
    import tpd_pkg::*;
#(
    parameter bit FULL_PD = 1'b1,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              pdbg,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              trc_acc,
    input  logic [DATA_W-1:0] trc_rdata,
    output logic              trc_stop,
    input  logic              trc_idle
);

    reg_cls_e cls;
    logic     access;
    logic     locked;
    logic     idle_ok;
    logic     sticky;
    logic     lock_wr;
    logic     pd_rd;

    assign access   = psel & penable;
    assign pready   = 1'b1;
    assign trc_stop = locked;

    tpd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (paddr),
        .cls  (cls)
    );

    tpd_lock #(.FULL_PD(FULL_PD), .DATA_W(DATA_W), .KEY(LOCK_KEY)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (lock_wr),
        .lock_wdata (pwdata),
        .pd_rd      (pd_rd),
        .trc_idle   (trc_idle),
        .locked     (locked),
        .idle_ok    (idle_ok),
        .sticky     (sticky)
    );

    tpd_resp #(.FULL_PD(FULL_PD), .DATA_W(DATA_W)) u_resp (
        .access    (access),
        .pwrite    (pwrite),
        .pdbg      (pdbg),
        .cls       (cls),
        .locked    (locked),
        .idle_ok   (idle_ok),
        .sticky    (sticky),
        .trc_rdata (trc_rdata),
        .prdata    (prdata),
        .pslverr   (pslverr),
        .trc_acc   (trc_acc),
        .lock_wr   (lock_wr),
        .pd_rd     (pd_rd)
    );

    assert_err_only_debugger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (pdbg && psel && penable && trc_stop));

    assert_err_not_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (!trc_acc && prdata == '0));

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && paddr >= ADDR_W'(TRACE_LIMIT) &&
         paddr != ADDR_W'(OFF_CLAIM_SET) && paddr != ADDR_W'(OFF_CLAIM_CLR))
        |-> (!pslverr && !trc_acc));

endmodule

// File: tb/tb_tpd_ctrl.sv
`timescale 1ns/1ps
module tb_tpd_ctrl;

    localparam logic [31:0] KEY = 32'h5EC0_10CC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pdbg = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] trc_rdata;
    logic        trc_idle = 1'b0;

    logic [31:0] f_rdata, s_rdata;
    logic        f_ready, s_ready, f_err, s_err, f_acc, s_acc, f_stop, s_stop;

    logic [31:0] r_fd, r_sd;
    logic        r_fe, r_se, r_fa, r_sa, r_fr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign trc_rdata = {20'hC0DE5, paddr};

    tpd_ctrl #(.FULL_PD(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pdbg(pdbg), .prdata(f_rdata), .pready(f_ready),
        .pslverr(f_err), .trc_acc(f_acc), .trc_rdata(trc_rdata), .trc_stop(f_stop),
        .trc_idle(trc_idle)
    );

    tpd_ctrl #(.FULL_PD(1'b0)) dut_sp (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pdbg(pdbg), .prdata(s_rdata), .pready(s_ready),
        .pslverr(s_err), .trc_acc(s_acc), .trc_rdata(trc_rdata), .trc_stop(s_stop),
        .trc_idle(trc_idle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One two-phase transfer; responses captured during the access phase.
    task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input logic dbg, input logic raise_idle);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d; pdbg = dbg;
        @(negedge clk);
        penable = 1'b1;
        if (raise_idle) trc_idle = 1'b1;
        #1;
        r_fd = f_rdata; r_sd = s_rdata; r_fe = f_err; r_se = s_err;
        r_fa = f_acc;   r_sa = s_acc;   r_fr = f_ready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic bit is_trace(input logic [11:0] a);
        return (a < 12'h300 && a != 12'h010) || a == 12'hFA0 || a == 12'hFA4;
    endfunction

    function automatic bit reads_zero(input logic [11:0] a);
        return !is_trace(a) && a != 12'h010 && a != 12'h304 && a != 12'h314;
    endfunction

    // Read every word address from the given requester and judge both builds.
    task automatic sweep(input logic dbg, input logic lk);
        for (int i = 0; i < 1024; i++) begin
            logic [11:0] a;
            logic        e;
            a = 12'(i * 4);
            xfer(1'b0, a, 32'h0, dbg, 1'b0);
            e = dbg & lk & is_trace(a);
            chk("R5 full pslverr", {31'b0, r_fe}, {31'b0, e});
            chk("R6 full trc_acc", {31'b0, r_fa}, {31'b0, is_trace(a) & ~e});
            chk("R2 single pslverr", {31'b0, r_se}, 32'h0);
            chk("R6 single trc_acc", {31'b0, r_sa}, {31'b0, is_trace(a)});
            if (is_trace(a)) begin
                chk("R5 full trace rdata", r_fd, e ? 32'h0 : {20'hC0DE5, a});
                chk("R5 single trace rdata", r_sd, {20'hC0DE5, a});
            end
            if (reads_zero(a)) begin
                chk("R10 full unmapped rdata", r_fd, 32'h0);
                chk("R10 single unmapped rdata", r_sd, 32'h0);
            end
            if (i % 64 == 0) chk("R5 pready", {31'b0, r_fr}, 32'h1);
        end
    endtask

    task automatic read_status(input string req, input logic [31:0] exp_full);
        xfer(1'b0, 12'h010, 32'h0, 1'b1, 1'b0);
        chk(req, r_fd, exp_full);
        chk("R2 single status", r_sd, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R3 stop after reset", {31'b0, f_stop}, 32'h1);
        chk("R2 single stop", {31'b0, s_stop}, 32'h0);
        xfer(1'b0, 12'h304, 32'h0, 1'b1, 1'b0);
        chk("R1 R3 lock status locked", r_fd, 32'h0000_000A);
        chk("R2 single lock status", r_sd, 32'h0);

        // Sticky set, locked: debugger trace access refused
        xfer(1'b0, 12'h000, 32'h0, 1'b1, 1'b0);
        chk("R9 refused with sticky set", {31'b0, r_fe}, 32'h1);

        // Processor clears the lock with a non-key value
        xfer(1'b1, 12'h300, 32'h1234_5678, 1'b0, 1'b0);
        chk("R4 clear write no error", {31'b0, r_fe}, 32'h0);
        chk("R4 stop dropped", {31'b0, f_stop}, 32'h0);
        xfer(1'b0, 12'h004, 32'h0, 1'b1, 1'b0);
        chk("R9 sticky has no effect unlocked", {31'b0, r_fe}, 32'h0);
        chk("R9 trace rdata", r_fd, {20'hC0DE5, 12'h004});

        // Sticky bit visible, then consumed by the read
        xfer(1'b0, 12'h314, 32'h0, 1'b0, 1'b0);
        chk("R9 pd status sticky", r_fd, 32'h0000_0003);
        chk("R2 single pd status", r_sd, 32'h0000_0001);
        xfer(1'b0, 12'h314, 32'h0, 1'b0, 1'b0);
        chk("R9 pd status sticky cleared", r_fd, 32'h0000_0001);

        // Debugger sets the lock with the key
        xfer(1'b1, 12'h300, KEY, 1'b1, 1'b0);
        chk("R4 stop raised", {31'b0, f_stop}, 32'h1);
        chk("R2 single ignores key", {31'b0, s_stop}, 32'h0);
        xfer(1'b0, 12'h304, 32'h0, 1'b1, 1'b0);
        chk("R4 lock status", r_fd, 32'h0000_000A);
        chk("R2 single lock status", r_sd, 32'h0);
        xfer(1'b0, 12'h314, 32'h0, 1'b1, 1'b0);
        chk("R3 pd status mirror", r_fd, 32'h0000_0021);
        xfer(1'b0, 12'h0FC, 32'h0, 1'b1, 1'b0);
        chk("R9 refused with sticky clear", {31'b0, r_fe}, 32'h1);

        // Drain handshake
        read_status("R7 idle before drain", 32'h0);
        @(negedge clk); trc_idle = 1'b1;
        read_status("R7 idle after drain", 32'h2);

        // Locked sweeps from both requesters
        sweep(1'b1, 1'b1);
        sweep(1'b0, 1'b1);

        // Writes under lock
        xfer(1'b1, 12'h100, 32'h0, 1'b1, 1'b0);
        chk("R5 trace write refused", {31'b0, r_fe}, 32'h1);
        xfer(1'b1, 12'hFA0, 32'h0, 1'b1, 1'b0);
        chk("R6 claim set refused", {31'b0, r_fe}, 32'h1);
        xfer(1'b1, 12'hFA4, 32'h0, 1'b1, 1'b0);
        chk("R6 claim clear refused", {31'b0, r_fe}, 32'h1);
        xfer(1'b1, 12'h100, 32'h0, 1'b0, 1'b0);
        chk("R5 processor trace write allowed", {31'b0, r_fa}, 32'h1);
        xfer(1'b1, 12'h308, 32'h0, 1'b1, 1'b0);
        chk("R10 save-restore write no error", {31'b0, r_fe | r_fa}, 32'h0);
        xfer(1'b0, 12'h308, 32'h0, 1'b1, 1'b0);
        chk("R10 save-restore reads zero", r_fd, 32'h0);
        xfer(1'b0, 12'h304, 32'h0, 1'b1, 1'b0);
        chk("R10 lock untouched by 0x308 write", r_fd, 32'h0000_000A);

        // Clear with the pipeline still idle: idle bit drops with the lock
        xfer(1'b1, 12'h300, 32'h0, 1'b0, 1'b0);
        chk("R8 stop dropped", {31'b0, f_stop}, 32'h0);
        read_status("R7 idle cleared with lock", 32'h0);

        // Relock while drained: idle follows one cycle later
        xfer(1'b1, 12'h300, KEY, 1'b0, 1'b0);
        read_status("R7 idle after relock", 32'h2);

        // Same-cycle drain acknowledge and clearing write
        xfer(1'b1, 12'h300, 32'h0, 1'b0, 1'b0);
        @(negedge clk); trc_idle = 1'b0;
        xfer(1'b1, 12'h300, KEY, 1'b0, 1'b0);
        read_status("R7 not idle before collision", 32'h0);
        xfer(1'b1, 12'h300, 32'hFFFF_FFFF, 1'b0, 1'b1);
        chk("R8 collision write no error", {31'b0, r_fe}, 32'h0);
        chk("R7 collision stop dropped", {31'b0, f_stop}, 32'h0);
        repeat (3) @(negedge clk);
        read_status("R7 collision idle stays clear", 32'h0);

        // Early clear without any drain
        @(negedge clk); trc_idle = 1'b0;
        xfer(1'b1, 12'h300, KEY, 1'b1, 1'b0);
        chk("R4 relock by debugger", {31'b0, f_stop}, 32'h1);
        xfer(1'b1, 12'h300, 32'h0, 1'b1, 1'b0);
        chk("R8 early clear no error", {31'b0, r_fe}, 32'h0);
        chk("R8 early clear stop dropped", {31'b0, f_stop}, 32'h0);
        xfer(1'b0, 12'h304, 32'h0, 1'b1, 1'b0);
        chk("R3 lock status unlocked", r_fd, 32'h0000_0008);
        xfer(1'b0, 12'h314, 32'h0, 1'b1, 1'b0);
        chk("R3 pd status unlocked", r_fd, 32'h0000_0001);

        // Unlocked sweep from the debugger
        sweep(1'b1, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule